// File: doc/BRIEF.md
# Release-on-Acknowledge VME Interrupter

This block raises VME interrupts for a register-based slave that carries two independent daughter modules. Each module delivers single-cycle event pulses. The block records each pulse in a pending bit, gates the pending bits with a mask, and drives one of the seven active-low request lines. Software picks that line through a level register. Level 0 silences the block. The block never asks for the data bus. Its only bus role is to interrupt and to answer acknowledge cycles.

When the interrupt handler runs an acknowledge cycle, the block takes part in the daisy chain. If the incoming grant is present, the acknowledged level matches the programmed level and a request is active, the block answers. It drives the status/ID byte and asserts DTACK. It also withdraws its request during that same cycle, so the request is released on acknowledge. In every other case where the grant is present, it passes the grant down the chain. The pending bits captured at the start of the answer are cleared when the data strobe rises. Events that arrive during the answer survive and request again afterwards.

The register port is a plain synchronous write strobe with a combinational read mux. It has no back-pressure: every write is accepted in the cycle it is presented. Mask and level writes are visible on readback at once. They steer the request lines and the acknowledge match only when the acknowledge machine is idle.

Top module: `vme_roak_irq`

## Requirements
- R1: After reset all seven request lines, DTACK and IACKOUT are high, D_OE is low, and the pending, mask, level and status/ID registers read 0.
- R2: A pulse on bit i of module A's event input sets pending bit i. A pulse on bit i of module B's event input sets pending bit SRC_PER_MOD+i. Pending reads back at register address 0 whatever the mask holds.
- R3: When any pending bit whose mask bit is 1 is set and the level (address 2, bits 2:0) is L in 1..7, line irq_n[L] is low and the other lines are high. Level 0 keeps every line high. At most one line is ever low.
- R4: A pending bit whose mask bit (address 1) is 0 does not cause a request.
- R5: A matching acknowledge is sampled on a clock edge with IACK, AS, DS and IACKIN all low, A3..A1 equal to the effective level, and a request active. From the next cycle DTACK stays low, D_OE is high and D7..D0 carry the status/ID register (address 3) until DS rises. IACKOUT stays high.
- R6: An acknowledge sampled with IACKIN low but with a level mismatch or no active request drives IACKOUT low from the next cycle, without DTACK, until AS rises. When IACKIN is high the block neither answers nor passes.
- R7: While the block answers an acknowledge, all request lines are high. On the first edge with DS high, the pending bits that were set and unmasked at the start of the answer are cleared.
- R8: An event that arrives during an answer stays pending. If it is unmasked, the request line goes low again once DTACK is released.
- R9: Mask and level writes made while an acknowledge is in progress read back at once. They change the request lines only after AS has risen and the block is idle.
- R10: Writes to the pending address leave the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_a_evt | input | SRC_PER_MOD | Event pulses from daughter module A |
| mod_b_evt | input | SRC_PER_MOD | Event pulses from daughter module B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 level, 3 status/ID |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| iack_n | input | 1 | Bus acknowledge-cycle indicator, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| iackin_n | input | 1 | Daisy-chain grant in, active low |
| ack_lvl | input | 3 | Acknowledged level from A3..A1 |
| iackout_n | output | 1 | Daisy-chain grant out, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| id_data | output | 8 | Status/ID byte for D7..D0 |
| id_oe | output | 1 | Drive enable for id_data |
| irq_n | output | 7 | Request lines, bit k is level k+1, active low |

## Verification
The assertions check four things on every cycle. No more than one request line is low. DTACK and IACKOUT are never low together. Every request line is high while DTACK is low. Once begun, a pass-down or an answer holds until the matching strobe rises. They also check that the effective mask and level stay frozen across a busy cycle. Only the bench scenarios can show the rest. These are which pending bits a given acknowledge clears, that events arriving mid-answer re-raise the request, that the status/ID byte is the value written, and that held configuration writes finally land once the cycle closes.

// File: rtl/vri_pkg.sv
package vri_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_RESP = 2'd2,
    ST_DONE = 2'd3
  } ack_st_e;

  localparam logic [1:0] RA_PEND = 2'd0;
  localparam logic [1:0] RA_MASK = 2'd1;
  localparam logic [1:0] RA_LVL  = 2'd2;
  localparam logic [1:0] RA_STID = 2'd3;

  localparam int unsigned LVL_W   = 3;
  localparam int unsigned N_LINES = 7;
endpackage

// File: rtl/vri_regs.sv
module vri_regs
  import vri_pkg::*;
#(
  parameter int unsigned PW = 8,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic [PW-1:0]    pending,
  input  logic             idle,
  output logic [DW-1:0]    rdata,
  output logic [PW-1:0]    mask_eff,
  output logic [LVL_W-1:0] lvl_eff,
  output logic [DW-1:0]    stat_id
);
  logic [PW-1:0]    mask_q;
  logic [LVL_W-1:0] lvl_q;

  // Software-visible copies: updated on every write, pending address ignored.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      lvl_q   <= '0;
      stat_id <= '0;
    end else if (wr) begin
      unique case (addr)
        RA_MASK: mask_q  <= wdata[PW-1:0];
        RA_LVL:  lvl_q   <= wdata[LVL_W-1:0];
        RA_STID: stat_id <= wdata;
        default: ;
      endcase
    end
  end

  // Effective copies follow only while no acknowledge is in flight.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_eff <= '0;
      lvl_eff  <= '0;
    end else if (idle) begin
      mask_eff <= mask_q;
      lvl_eff  <= lvl_q;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_PEND: rdata[PW-1:0]    = pending;
      RA_MASK: rdata[PW-1:0]    = mask_q;
      RA_LVL:  rdata[LVL_W-1:0] = lvl_q;
      RA_STID: rdata            = stat_id;
      default: rdata            = '0;
    endcase
  end

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(mask_eff) && $stable(lvl_eff)));
endmodule

// File: rtl/vri_merge.sv
module vri_merge #(
  parameter int unsigned SPM = 4,
  localparam int unsigned PW = 2 * SPM
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPM-1:0] evt_a,
  input  logic [SPM-1:0] evt_b,
  input  logic [PW-1:0]  mask_eff,
  input  logic           ack_start,
  input  logic           ack_end,
  output logic [PW-1:0]  pending,
  output logic           req_any
);
  logic [PW-1:0] evt_all;
  logic [PW-1:0] snap;
  logic [PW-1:0] clr_vec;

  // Module B occupies the upper half of the pending vector.
  assign evt_all = {evt_b, evt_a};
  assign clr_vec = ack_end ? snap : '0;
  assign req_any = |(pending & mask_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) snap <= '0;
    else if (ack_start) snap <= pending & mask_eff;
  end

  // A new event wins over a clear landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else pending <= (pending & ~clr_vec) | evt_all;
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_all) |=> ((pending & $past(evt_all)) == $past(evt_all)));
endmodule

// File: rtl/vri_iack_fsm.sv
module vri_iack_fsm
  import vri_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_n,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic             iackin_n,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic [LVL_W-1:0] lvl_eff,
  input  logic             req_any,
  input  logic [DW-1:0]    stat_id,
  output logic             ack_start,
  output logic             ack_end,
  output logic             idle,
  output logic             responding,
  output logic             iackout_n,
  output logic             dtack_n,
  output logic [DW-1:0]    id_data,
  output logic             id_oe
);
  ack_st_e st_q, st_d;
  logic    grant;
  logic    ours;

  assign grant = !iack_n && !as_n && !ds_n && !iackin_n;
  assign ours  = req_any && (lvl_eff != '0) && (ack_lvl == lvl_eff);

  assign ack_start  = (st_q == ST_IDLE) && grant && ours;
  assign ack_end    = (st_q == ST_RESP) && ds_n;
  assign idle       = (st_q == ST_IDLE);
  assign responding = (st_q == ST_RESP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (grant) st_d = ours ? ST_RESP : ST_PASS;
      ST_PASS: if (as_n) st_d = ST_IDLE;
      ST_RESP: if (ds_n) st_d = ST_DONE;
      ST_DONE: if (as_n) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) id_data <= '0;
    else if (ack_start) id_data <= stat_id;
  end

  assign dtack_n   = (st_q != ST_RESP);
  assign id_oe     = (st_q == ST_RESP);
  assign iackout_n = (st_q != ST_PASS);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !iackout_n));
  p_dtack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !ds_n) |=> !dtack_n);
  p_pass_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!iackout_n && !as_n) |=> !iackout_n);
  p_pass_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!iackout_n && as_n) |=> iackout_n);
endmodule

// File: rtl/vri_irq_drive.sv
module vri_irq_drive
  import vri_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_any,
  input  logic               responding,
  input  logic [LVL_W-1:0]   lvl_eff,
  output logic [N_LINES-1:0] irq_n
);
  logic active;
  assign active = req_any && !responding;

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    assign irq_n[k] = !(active && (lvl_eff == LVL_W'(k + 1)));
  end

  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1);
endmodule

// File: rtl/vme_roak_irq.sv
module vme_roak_irq
  import vri_pkg::*;
#(
  parameter int unsigned SRC_PER_MOD = 4,
  parameter int unsigned DW          = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_PER_MOD-1:0] mod_a_evt,
  input  logic [SRC_PER_MOD-1:0] mod_b_evt,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic                   iack_n,
  input  logic                   as_n,
  input  logic                   ds_n,
  input  logic                   iackin_n,
  input  logic [2:0]             ack_lvl,
  output logic                   iackout_n,
  output logic                   dtack_n,
  output logic [DW-1:0]          id_data,
  output logic                   id_oe,
  output logic [6:0]             irq_n
);
  localparam int unsigned PW = 2 * SRC_PER_MOD;

  logic [PW-1:0]    pending;
  logic [PW-1:0]    mask_eff;
  logic [LVL_W-1:0] lvl_eff;
  logic [DW-1:0]    stat_id;
  logic             req_any, ack_start, ack_end, idle, responding;

  initial begin
    if (PW > DW) $error("pending vector wider than register data");
  end

  vri_regs #(.PW(PW), .DW(DW)) u_regs (
    .clk, .rst_n, .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pending, .idle, .rdata(reg_rdata), .mask_eff, .lvl_eff, .stat_id
  );

  vri_merge #(.SPM(SRC_PER_MOD)) u_merge (
    .clk, .rst_n, .evt_a(mod_a_evt), .evt_b(mod_b_evt), .mask_eff,
    .ack_start, .ack_end, .pending, .req_any
  );

  vri_iack_fsm #(.DW(DW)) u_fsm (
    .clk, .rst_n, .iack_n, .as_n, .ds_n, .iackin_n, .ack_lvl, .lvl_eff,
    .req_any, .stat_id, .ack_start, .ack_end, .idle, .responding,
    .iackout_n, .dtack_n, .id_data, .id_oe
  );

  vri_irq_drive u_irq (
    .clk, .rst_n, .req_any, .responding, .lvl_eff, .irq_n
  );

  p_roak_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (&irq_n));
endmodule

// File: tb/sim_vme_roak_irq.sv
module sim_vme_roak_irq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] mod_a_evt = '0, mod_b_evt = '0;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       iack_n = 1, as_n = 1, ds_n = 1, iackin_n = 1;
  logic [2:0] ack_lvl = '0;
  logic       iackout_n, dtack_n, id_oe;
  logic [7:0] id_data;
  logic [6:0] irq_n;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vme_roak_irq u0 (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] line_exp(int lvl);
    return (lvl == 0) ? 7'h7F : ~(7'(1) << (lvl - 1));
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [3:0] a, logic [3:0] b);
    mod_a_evt = a; mod_b_evt = b; tick(); mod_a_evt = '0; mod_b_evt = '0;
  endtask

  task automatic bus_start(logic [2:0] l, logic gin_n);
    iack_n = 0; as_n = 0; ds_n = 0; iackin_n = gin_n; ack_lvl = l; tick();
  endtask

  task automatic bus_end();
    ds_n = 1; tick(); as_n = 1; iack_n = 1; iackin_n = 1; tick();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", irq_n, 7'h7F);
    chk("R1 dtack", dtack_n, 1); chk("R1 iackout", iackout_n, 1);
    chk("R1 oe", id_oe, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 regs", v, 0);
    end
  endtask

  task automatic t_mask_gate();
    logic [7:0] v;
    wr(2, 3); wr(1, 8'h0F); tick();
    pulse(4'b0000, 4'b0100);
    rd(0, v); chk("R2 pending from B", v, 8'h40);
    chk("R4 masked no irq", irq_n, 7'h7F);
    wr(0, 8'hFF); rd(0, v); chk("R10 pending write ignored", v, 8'h40);
    wr(1, 8'hF0); tick();
    chk("R3 level 3", irq_n, line_exp(3));
  endtask

  task automatic t_levels();
    wr(2, 0); tick(); chk("R3 level 0 silent", irq_n, 7'h7F);
    wr(2, 6); tick(); chk("R3 level 6", irq_n, line_exp(6));
    wr(2, 3); tick(); chk("R3 level 3 back", irq_n, line_exp(3));
  endtask

  task automatic t_pass();
    bus_start(5, 0);
    chk("R6 pass iackout", iackout_n, 0); chk("R6 no dtack", dtack_n, 1);
    tick(); chk("R6 pass held", iackout_n, 0);
    ds_n = 1; as_n = 1; iack_n = 1; iackin_n = 1; tick();
    chk("R6 pass released", iackout_n, 1);
    bus_start(3, 1);
    chk("R6 no grant no dtack", dtack_n, 1); chk("R6 no grant no pass", iackout_n, 1);
    ds_n = 1; as_n = 1; iack_n = 1; iackin_n = 1; tick();
  endtask

  task automatic t_answer();
    logic [7:0] v;
    wr(3, 8'hA5); wr(1, 8'hFF); tick();
    bus_start(3, 0);
    chk("R5 dtack", dtack_n, 0); chk("R5 id", id_data, 8'hA5);
    chk("R5 oe", id_oe, 1); chk("R5 iackout high", iackout_n, 1);
    chk("R7 withdrawn", irq_n, 7'h7F);
    pulse(4'b0001, 4'b0000);
    chk("R5 dtack held", dtack_n, 0);
    ds_n = 1; tick();
    rd(0, v); chk("R7 R8 pending after ack", v, 8'h01);
    chk("R5 dtack released", dtack_n, 1);
    chk("R8 request again", irq_n, line_exp(3));
    as_n = 1; iack_n = 1; iackin_n = 1; tick();
  endtask

  task automatic t_cfg_hold();
    logic [7:0] v;
    bus_start(3, 0);
    chk("R9 answering", dtack_n, 0);
    pulse(4'b0010, 4'b0000);
    wr(1, 8'h00); wr(2, 6);
    rd(1, v); chk("R9 mask readback", v, 8'h00);
    ds_n = 1; tick();
    rd(0, v); chk("R9 pending", v, 8'h02);
    chk("R9 old cfg holds", irq_n, line_exp(3));
    as_n = 1; iack_n = 1; iackin_n = 1; tick(); tick();
    chk("R9 new mask applied", irq_n, 7'h7F);
    rd(2, v); chk("R9 level readback", v, 8'h06);
    wr(1, 8'h02); tick();
    chk("R9 new level applied", irq_n, line_exp(6));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_mask_gate();
    t_levels();
    t_pass();
    t_answer();
    t_cfg_hold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule